// File: doc/BRIEF.md
# Prescaled PWM Timer Channel

This block drives one pulse-width-modulated output from a reference clock. A power-of-two prescaler turns the clock into slow ticks. Each output period spans a programmed number of ticks, and the output stays high for the first few ticks of each period, as set by a programmed active count. Software reaches the block through a plain single-cycle register port. A write strobe, an address and write data go in. Read data comes back combinationally for the address presented.

New settings are first staged in shadow copies. When the channel is idle, the live setting copies them on the following clock. When it is running, the copy waits for the next period boundary, so a period is never cut short or stretched. A staging bit lets software set period, active count and prescaler one at a time while the output keeps running on the old values. The new values then take over together once the bit is cleared. Settings with a zero field are refused, either at the staging copy or when the output is started.

The register port carries no data stream, so it has no valid/ready handshake. Every write is accepted in the cycle its strobe is high, and no back-pressure exists.

Top module: `ptp_top`

## Requirements
- R1: After reset both registers read zero and `pwm_out` is 0.
- R2: Control register at offset 0x0. Bit 0 is run, bit 4 is a stored clock-select flag with no effect on the output, bit 11 is the staging (hold) bit, bit 15 is the exponent low bit and bits 19:16 are the exponent high field. All other bits read 0.
- R3: Count register at offset 0x4. The period count is bits 25:16 and the active count is bits 9:0. It reads back the last values written. All other bits read 0.
- R4: The exponent is twice the high field plus the low bit, and a tick occurs every 2^exponent clocks. A requested exponent above 24 is stored as 24, which reads back as high field 12 and low bit 0.
- R5: While running, the output is high for active×2^exp clocks and then low for (period−active)×2^exp clocks, repeating. The first clock after the edge that starts the run is the first high clock.
- R6: An active count equal to or greater than the period count keeps the output high the whole time.
- R7: A write setting run while the live period or active count is zero is ignored, and run reads back 0.
- R8: A staged count with a zero field is never copied to the live setting, and the previous live counts remain in use.
- R9: While the hold bit is set, writes to the count or exponent do not change the output.
- R10: While running with hold clear, staged values become live together at the next period boundary.
- R11: While stopped with hold clear, staged values become live on the clock after the write that staged them.
- R12: Clearing run drives the output low from the next clock. A later start begins a new period at tick zero.
- R13: Writes to any address other than 0x0 and 0x4 change no register and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | 1 | Modulated output |

## Verification
A write is captured at the clock edge where the strobe is high. Read data and `pwm_out` reflect it right after that edge. A staged setting reaches the output one edge later when the channel is stopped, or at the edge that ends the current period when it is running. The bench changes inputs just after each rising edge and runs a behavioural model on the same edge. It then compares both outputs at the falling edge, so every result is checked in the exact cycle it is due.

// File: rtl/ptp_pkg.sv
`timescale 1ns/1ps
package ptp_pkg;
  localparam int REG_W    = 32;
  localparam int CNT_W    = 10;
  localparam int EXP_HI_W = 4;
  localparam int EXP_W    = EXP_HI_W + 1;
  localparam int EXP_MAX  = 24;
  localparam int DIV_W    = EXP_MAX;

  localparam int OFS_CTRL  = 'h0;
  localparam int OFS_COUNT = 'h4;

  // control register bit positions
  localparam int CB_RUN       = 0;
  localparam int CB_CLKSEL    = 4;
  localparam int CB_HOLD      = 11;
  localparam int CB_EXPLO     = 15;
  localparam int CB_EXPHI_LSB = 16;

  // count register field positions
  localparam int NB_PER_LSB = 16;
  localparam int NB_ACT_LSB = 0;

  typedef struct packed {
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] phase;
    logic [EXP_W-1:0] expo;
  } ptp_cfg_t;
endpackage

// File: rtl/ptp_regs.sv
`timescale 1ns/1ps
module ptp_regs
  import ptp_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              boundary,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              run,
  output ptp_cfg_t          live
);
  logic wr_ctrl, wr_count;
  logic [EXP_W-1:0] exp_raw, exp_sat;
  ptp_cfg_t stage_q, live_q;
  logic run_q, hold_q, clksel_q, pend_q;
  logic live_ok, stage_ok, commit;

  assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
  assign wr_count = bus_wr && (bus_addr == ADDR_W'(OFS_COUNT));

  // exponent = high field * 2 + low bit, saturated at the maximum
  assign exp_raw = {bus_wdata[CB_EXPHI_LSB +: EXP_HI_W], bus_wdata[CB_EXPLO]};
  assign exp_sat = (exp_raw > EXP_W'(EXP_MAX)) ? EXP_W'(EXP_MAX) : exp_raw;

  assign live_ok  = (live_q.period != '0) && (live_q.phase != '0);
  assign stage_ok = (stage_q.period != '0) && (stage_q.phase != '0);
  assign commit   = pend_q && !hold_q && (boundary || !run_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= '0;
      live_q   <= '0;
      run_q    <= 1'b0;
      hold_q   <= 1'b0;
      clksel_q <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      if (commit) begin
        live_q.expo <= stage_q.expo;
        if (stage_ok) begin
          live_q.period <= stage_q.period;
          live_q.phase  <= stage_q.phase;
        end
        pend_q <= 1'b0;
      end
      if (wr_ctrl) begin
        hold_q       <= bus_wdata[CB_HOLD];
        clksel_q     <= bus_wdata[CB_CLKSEL];
        stage_q.expo <= exp_sat;
        pend_q       <= 1'b1;
        if (bus_wdata[CB_RUN]) begin
          if (!run_q) run_q <= live_ok;
        end else begin
          run_q <= 1'b0;
        end
      end
      if (wr_count) begin
        stage_q.period <= bus_wdata[NB_PER_LSB +: CNT_W];
        stage_q.phase  <= bus_wdata[NB_ACT_LSB +: CNT_W];
        pend_q         <= 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_CTRL)) begin
      bus_rdata[CB_RUN]                      = run_q;
      bus_rdata[CB_CLKSEL]                   = clksel_q;
      bus_rdata[CB_HOLD]                     = hold_q;
      bus_rdata[CB_EXPLO]                    = stage_q.expo[0];
      bus_rdata[CB_EXPHI_LSB +: EXP_HI_W]    = stage_q.expo[EXP_W-1:1];
    end else if (bus_addr == ADDR_W'(OFS_COUNT)) begin
      bus_rdata[NB_PER_LSB +: CNT_W] = stage_q.period;
      bus_rdata[NB_ACT_LSB +: CNT_W] = stage_q.phase;
    end
  end

  assign run  = run_q;
  assign live = live_q;

  assert_run_needs_counts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> live_ok);
  assert_hold_freezes_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |=> $stable(live_q));
  assert_zero_count_kept_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !stage_ok) |=> $stable({live_q.period, live_q.phase}));
  assert_expo_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q.expo <= EXP_W'(EXP_MAX)) && (stage_q.expo <= EXP_W'(EXP_MAX)));
endmodule

// File: rtl/ptp_prescaler.sv
`timescale 1ns/1ps
module ptp_prescaler
  import ptp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [EXP_W-1:0] expo,
  output logic             tick
);
  logic [DIV_W-1:0] div_q, lim;

  assign lim  = ~({DIV_W{1'b1}} << expo);
  assign tick = run && (div_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             div_q <= '0;
    else if (!run || tick)  div_q <= '0;
    else                    div_q <= div_q + DIV_W'(1);
  end

  assert_start_from_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (div_q == '0));
endmodule

// File: rtl/ptp_period.sv
`timescale 1ns/1ps
module ptp_period
  import ptp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] phase,
  output logic             boundary,
  output logic             wave
);
  logic [CNT_W-1:0] pos_q;

  assign boundary = tick && (pos_q == period - CNT_W'(1));
  assign wave     = run && (pos_q < phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pos_q <= '0;
    else if (!run)     pos_q <= '0;
    else if (tick)     pos_q <= boundary ? '0 : pos_q + CNT_W'(1);
  end

  assert_pos_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (pos_q < period));
  assert_hold_between_ticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(pos_q));
endmodule

// File: rtl/ptp_top.sv
`timescale 1ns/1ps
module ptp_top
  import ptp_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              pwm_out
);
  logic     run, tick, boundary;
  ptp_cfg_t live;

  ptp_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .boundary(boundary), .bus_rdata(bus_rdata),
    .run(run), .live(live)
  );

  ptp_prescaler presc_i (
    .clk(clk), .rst_n(rst_n), .run(run), .expo(live.expo), .tick(tick)
  );

  ptp_period per_i (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
    .period(live.period), .phase(live.phase),
    .boundary(boundary), .wave(pwm_out)
  );

  assert_low_when_reset_R1: assert property (@(posedge clk)
    !rst_n |-> !pwm_out);
endmodule

// File: tb/ptp_top_tb_top.sv
`timescale 1ns/1ps
module ptp_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwm_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  string cur_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  ptp_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  // behavioural reference: period measured in raw clocks
  bit     m_run, m_hold, m_clksel, m_pend;
  int     st_per, st_ph, st_exp, lv_per, lv_ph, lv_exp;
  longint t;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_hold = 0; m_clksel = 0; m_pend = 0;
      st_per = 0; st_ph = 0; st_exp = 0; lv_per = 0; lv_ph = 0; lv_exp = 0;
      t = 0;
    end else begin
      bit bnd, cmt, en_ok;
      bnd   = m_run && (t == ((longint'(lv_per)) << lv_exp) - 1);
      cmt   = m_pend && !m_hold && (bnd || !m_run);
      en_ok = (lv_per != 0) && (lv_ph != 0);
      if (!m_run || bnd) t = 0; else t = t + 1;
      if (cmt) begin
        lv_exp = st_exp;
        if (st_per != 0 && st_ph != 0) begin lv_per = st_per; lv_ph = st_ph; end
        m_pend = 0;
      end
      if (bus_wr && bus_addr == 4'h0) begin
        int e;
        e = int'(bus_wdata[19:16]) * 2 + int'(bus_wdata[15]);
        if (e > 24) e = 24;
        st_exp = e; m_hold = bus_wdata[11]; m_clksel = bus_wdata[4]; m_pend = 1;
        if (bus_wdata[0]) begin
          if (!m_run) m_run = en_ok;
        end else m_run = 0;
      end
      if (bus_wr && bus_addr == 4'h4) begin
        st_per = int'(bus_wdata[25:16]); st_ph = int'(bus_wdata[9:0]); m_pend = 1;
      end
    end
  end

  function automatic logic [31:0] model_rd(input logic [3:0] a);
    logic [31:0] r;
    r = '0;
    if (a == 4'h0) begin
      r[0] = m_run; r[4] = m_clksel; r[11] = m_hold;
      r[15] = st_exp[0]; r[19:16] = st_exp[4:1];
    end else if (a == 4'h4) begin
      r[25:16] = st_per[9:0]; r[9:0] = st_ph[9:0];
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic exp_out;
      exp_out = m_run && (t < ((longint'(lv_ph)) << lv_exp));
      chk({cur_tag, " pwm_out"}, {31'b0, pwm_out}, {31'b0, exp_out});
      chk({cur_tag, " rdata"}, bus_rdata, model_rd(bus_addr));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    @(posedge clk); #1;
    bus_addr = a;
    @(negedge clk);
    chk(tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [4:0] pat;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    cur_tag = "R1";
    rd_chk("R1 ctrl after reset", 4'h0, 32'h0);
    rd_chk("R1 count after reset", 4'h4, 32'h0);
    chk("R1 output after reset", {31'b0, pwm_out}, 32'h0);

    cur_tag = "R7";
    wr(4'h0, 32'h1);
    rd_chk("R7 run refused with zero counts", 4'h0, 32'h0);

    cur_tag = "R11";
    wr(4'h4, {6'h0, 10'd5, 6'h0, 10'd2});
    rd_chk("R3 count readback", 4'h4, 32'h0005_0002);

    cur_tag = "R5";
    wr(4'h0, 32'h1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      pat[4-i] = pwm_out;
    end
    chk("R5 first period pattern", {27'b0, pat}, {27'b0, 5'b11000});
    idle(20);

    cur_tag = "R10";
    wr(4'h0, 32'h0000_8001);   // exponent 1
    idle(40);

    cur_tag = "R9";
    wr(4'h0, 32'h0000_8801);   // hold set
    wr(4'h4, {6'h0, 10'd3, 6'h0, 10'd1});
    wr(4'h0, 32'h0001_0801);   // exponent 2, hold still set
    idle(30);
    wr(4'h0, 32'h0001_0001);   // release hold
    idle(60);

    cur_tag = "R6";
    wr(4'h4, {6'h0, 10'd4, 6'h0, 10'd7});
    idle(40);

    cur_tag = "R12";
    wr(4'h0, 32'h0);
    @(negedge clk);
    chk("R12 output low after stop", {31'b0, pwm_out}, 32'h0);
    wr(4'h4, {6'h0, 10'd6, 6'h0, 10'd3});
    idle(3);
    wr(4'h0, 32'h1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      pat[4-i] = pwm_out;
    end
    chk("R12 restart from tick zero", {27'b0, pat}, {27'b0, 5'b11100});
    idle(15);

    cur_tag = "R8";
    wr(4'h4, {6'h0, 10'd0, 6'h0, 10'd3});
    idle(30);
    rd_chk("R8 staged zero readback", 4'h4, 32'h0000_0003);

    cur_tag = "R13";
    wr(4'h8, 32'hFFFF_FFFF);
    wr(4'h2, 32'h0000_0000);
    rd_chk("R13 ctrl untouched", 4'h0, 32'h0000_0001);
    rd_chk("R13 count untouched", 4'h4, 32'h0000_0003);
    idle(10);

    cur_tag = "R3";
    wr(4'h4, 32'hFFFF_FFFF);
    rd_chk("R3 count field mask", 4'h4, 32'h03FF_03FF);
    idle(10);

    cur_tag = "R2";
    wr(4'h0, 32'hFFFF_FFFE);
    rd_chk("R2 ctrl mask and R4 clamp", 4'h0, 32'h000C_0810);
    wr(4'h0, 32'h0000_0000);
    rd_chk("R2 ctrl cleared", 4'h0, 32'h0);

    cur_tag = "R4";
    wr(4'h4, {6'h0, 10'd3, 6'h0, 10'd2});
    wr(4'h0, 32'h0001_8001);   // exponent 3
    idle(60);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule